// File: doc/BRIEF.md
# Serial Bitstream Configuration Loader

This block configures a target programmable-logic device over a one-bit serial link. After a start pulse it pulls the target's program line low and waits for the target to answer on its active-low init line. It then releases program and waits for init to return high. After that it takes the given number of bytes from a valid/ready stream and shifts each one out on a data pin, most significant bit first, with a generated configuration clock. Once the last byte has gone out, it holds the data pin high and keeps clocking until the target raises done.

Each wait on the target is bounded by a timeout counted in system clock cycles. Before every byte the block checks for the load-error signature, which is init low while done is still low, and aborts if it sees it. The end of every run, good or bad, gives a one-cycle completion pulse and exactly one sticky status flag. The stream side applies back-pressure only through `s_ready`. A byte is taken in any cycle where `s_valid` and `s_ready` are both high. `s_data` has to be stable while `s_valid` is high and `s_ready` is low. A stalled stream is waited on without limit.

Top module: `cfg_serial_loader`

## Requirements
- R1: A `start` pulse seen while idle (`busy`=0) drives `tgt_prog_n` low in the next cycle, raises `busy`, clears all three status flags and latches `byte_total`; `start` while busy has no effect on any output.
- R2: `tgt_prog_n` stays low until `tgt_init_n` is sampled low, then returns high; no byte is accepted before `tgt_init_n` has been sampled high after that.
- R3: Each of the two init waits and the final done wait ends after `TMO_CYCLES` cycles without the awaited level; the block then goes idle with `load_timeout`=1 and `tgt_prog_n`=1.
- R4: Each byte is sent most significant bit first as 8 clock periods; `tgt_din` changes only while `tgt_cclk` is low, so the target samples it on the rising edge.
- R5: Every low and every high phase of `tgt_cclk` lasts `div_cycles` system cycles (a value of 0 acts as 1); `tgt_cclk` is low whenever no bit or trailing clock is being produced.
- R6: `s_ready` is high only while the block waits for a byte with bytes still owed and no load error present; exactly `byte_total` bytes are accepted per run.
- R7: When waiting to send a byte, sampling `tgt_init_n`=0 with `tgt_done`=0 ends the run with `load_crc_err`=1 and no further byte accepted.
- R8: After the last byte `tgt_din` is held at 1 while clock pulses continue; sampling `tgt_done`=1 ends the run with `load_ok`=1 and `tgt_cclk` low.
- R9: Every run ends with `done_pulse` high for exactly one cycle as `busy` falls; at most one status flag is set, and it stays set until the next accepted start.
- R10: With `byte_total`=0 the block goes from the init handshake straight to the trailing clock phase without raising `s_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a configuration run (honoured only when idle) |
| byte_total | input | LEN_W | Number of bitstream bytes for the run |
| div_cycles | input | DIV_W | System cycles per configuration clock phase |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Loader accepts a byte this cycle |
| tgt_prog_n | output | 1 | Active-low program request to the target |
| tgt_init_n | input | 1 | Active-low init / error indication from the target |
| tgt_done | input | 1 | Target configuration complete |
| tgt_cclk | output | 1 | Configuration clock to the target |
| tgt_din | output | 1 | Serial configuration data |
| busy | output | 1 | A run is in progress |
| done_pulse | output | 1 | One-cycle end-of-run strobe |
| load_ok | output | 1 | Sticky: last run finished with done high |
| load_timeout | output | 1 | Sticky: last run hit a wait timeout |
| load_crc_err | output | 1 | Sticky: last run saw a load error |

## Verification
The assertions assume that `start` comes only after a reset that lasts at least one clock. They also assume `div_cycles` holds steady for a whole run, because the phase-length and data-setup properties depend on a fixed divider. The bench changes `div_cycles` and `byte_total` only between runs, while the loader is idle. Its emulated target moves init and done only on falling clock edges, and its stream source keeps data stable until a handshake.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_REL,
    ST_GETB,
    ST_SHIFT,
    ST_FLUSH
  } cfgl_state_t;

  localparam int BYTE_BITS = 8;
endpackage

// File: rtl/cfgl_clkgen.sv
module cfgl_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             cclk,
  output logic             bit_end
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             last;

  assign lim     = (div == '0) ? DIV_W'(1) : div;
  assign last    = (cnt == lim - DIV_W'(1));
  assign bit_end = last && cclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      cclk <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
      cclk <= 1'b0;
    end else if (last) begin
      cnt  <= '0;
      cclk <= ~cclk;
    end else begin
      cnt  <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/cfgl_timer.sv
module cfgl_timer #(
  parameter int LIMIT = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  assign expired = (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (!expired)   cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/cfgl_shifter.sv
module cfgl_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sh;

  assign msb = sh[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= din;
    else if (shift) sh <= {sh[W-2:0], 1'b0};
  end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
  parameter int LEN_W      = 16,
  parameter int DIV_W      = 8,
  parameter int TMO_CYCLES = 2_500_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] byte_total,
  input  logic [DIV_W-1:0] div_cycles,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  output logic             s_ready,
  output logic             tgt_prog_n,
  input  logic             tgt_init_n,
  input  logic             tgt_done,
  output logic             tgt_cclk,
  output logic             tgt_din,
  output logic             busy,
  output logic             done_pulse,
  output logic             load_ok,
  output logic             load_timeout,
  output logic             load_crc_err
);
  import cfgl_pkg::*;

  localparam int BIT_W = $clog2(BYTE_BITS);

  cfgl_state_t      st, st_nx;
  logic [LEN_W-1:0] left;
  logic [BIT_W-1:0] bit_idx;
  logic             bit_end, tmo_hit, crc_cond, take, sh_msb;
  logic             run_now, run_nxt;
  logic             fin_ok, fin_tmo, fin_crc;

  assign crc_cond = !tgt_done && !tgt_init_n;
  assign s_ready  = (st == ST_GETB) && !crc_cond && (left != '0);
  assign take     = s_ready && s_valid;
  assign run_now  = (st == ST_SHIFT) || (st == ST_FLUSH);
  assign run_nxt  = (st_nx == ST_SHIFT) || (st_nx == ST_FLUSH);

  always_comb begin
    st_nx   = st;
    fin_ok  = 1'b0;
    fin_tmo = 1'b0;
    fin_crc = 1'b0;
    unique case (st)
      ST_IDLE:  if (start) st_nx = ST_PROG;
      ST_PROG: begin
        if (!tgt_init_n) st_nx = ST_REL;
        else if (tmo_hit) begin st_nx = ST_IDLE; fin_tmo = 1'b1; end
      end
      ST_REL: begin
        if (tgt_init_n) st_nx = ST_GETB;
        else if (tmo_hit) begin st_nx = ST_IDLE; fin_tmo = 1'b1; end
      end
      ST_GETB: begin
        if (crc_cond) begin st_nx = ST_IDLE; fin_crc = 1'b1; end
        else if (left == '0) st_nx = ST_FLUSH;
        else if (s_valid) st_nx = ST_SHIFT;
      end
      ST_SHIFT: if (bit_end && bit_idx == BIT_W'(BYTE_BITS - 1)) st_nx = ST_GETB;
      ST_FLUSH: begin
        if (tgt_done) begin st_nx = ST_IDLE; fin_ok = 1'b1; end
        else if (tmo_hit) begin st_nx = ST_IDLE; fin_tmo = 1'b1; end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      left         <= '0;
      bit_idx      <= '0;
      done_pulse   <= 1'b0;
      load_ok      <= 1'b0;
      load_timeout <= 1'b0;
      load_crc_err <= 1'b0;
    end else begin
      st         <= st_nx;
      done_pulse <= fin_ok || fin_tmo || fin_crc;
      if (st == ST_IDLE && start) begin
        left         <= byte_total;
        load_ok      <= 1'b0;
        load_timeout <= 1'b0;
        load_crc_err <= 1'b0;
      end else begin
        if (take) left <= left - LEN_W'(1);
        if (fin_ok)  load_ok      <= 1'b1;
        if (fin_tmo) load_timeout <= 1'b1;
        if (fin_crc) load_crc_err <= 1'b1;
      end
      if (take) bit_idx <= '0;
      else if (st == ST_SHIFT && bit_end) bit_idx <= bit_idx + BIT_W'(1);
    end
  end

  cfgl_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(run_now && run_nxt), .div(div_cycles),
    .cclk(tgt_cclk), .bit_end(bit_end)
  );

  cfgl_timer #(.LIMIT(TMO_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clear(st_nx != st), .expired(tmo_hit)
  );

  cfgl_shifter #(.W(BYTE_BITS)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(take), .din(s_data),
    .shift(st == ST_SHIFT && bit_end), .msb(sh_msb)
  );

  assign tgt_prog_n = (st != ST_PROG);
  assign busy       = (st != ST_IDLE);
  assign tgt_din    = (st == ST_FLUSH) ? 1'b1 : ((st == ST_SHIFT) ? sh_msb : 1'b0);
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic s_ready,
  input logic tgt_prog_n,
  input logic tgt_cclk,
  input logic tgt_din,
  input logic done_pulse,
  input logic load_ok,
  input logic load_timeout,
  input logic load_crc_err
);
  assert_prog_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_prog_n) |-> $past(start));

  assert_din_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_cclk) |-> $stable(tgt_din));

  assert_din_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_cclk && $past(tgt_cclk)) |-> $stable(tgt_din));

  assert_cclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tgt_cclk);

  assert_ready_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (busy && tgt_prog_n && !tgt_cclk));

  assert_pulse_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (!busy && $past(busy)));

  assert_status_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_ok, load_timeout, load_crc_err}));
endmodule

bind cfg_serial_loader cfg_serial_loader_chk chk_i (.*);

// File: tb/cfg_serial_loader_tb_top.sv
module cfg_serial_loader_tb_top;
  localparam int TMO = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] byte_total = '0;
  logic [7:0]  div_cycles = 8'd1;
  logic s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic tb_init_n = 1'b1;
  logic tb_done = 1'b0;
  logic s_ready, tgt_prog_n, tgt_cclk, tgt_din, busy, done_pulse;
  logic load_ok, load_timeout, load_crc_err;

  always #2 clk = ~clk;

  cfg_serial_loader #(.LEN_W(16), .DIV_W(8), .TMO_CYCLES(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_total(byte_total),
    .div_cycles(div_cycles), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .tgt_prog_n(tgt_prog_n), .tgt_init_n(tb_init_n), .tgt_done(tb_done),
    .tgt_cclk(tgt_cclk), .tgt_din(tgt_din), .busy(busy), .done_pulse(done_pulse),
    .load_ok(load_ok), .load_timeout(load_timeout), .load_crc_err(load_crc_err)
  );

  int vectors = 0;
  int fails = 0;

  // scenario knobs
  int k_total = 0, k_gap = 0, k_extra = 1, k_lo_dly = 3, k_hi_dly = 4, k_crc_byte = -1;
  bit k_never_low = 0, k_never_high = 0, k_never_done = 0;
  int arm_req = 0, arm_seen = 0;
  logic [7:0] src_q[$];
  logic [7:0] rx_q[$];

  // reference model state: 0 idle,1 program,2 release,3 byte wait,4 shift,5 trailing clocks
  int m_st = 0, m_tmr = 0, m_ph = 0, m_bit = 0, m_left = 0;
  bit m_cclk = 0, m_pulse = 0, m_ok = 0, m_tmo = 0, m_crc = 0;
  logic [7:0] m_byte = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_tmr = 0; m_ph = 0; m_cclk = 0; m_pulse = 0;
      m_ok = 0; m_tmo = 0; m_crc = 0; m_left = 0; m_bit = 0; m_byte = '0;
    end else begin
      int ns, lim;
      bit bend, crcc, was_run;
      lim = (div_cycles == 0) ? 1 : int'(div_cycles);
      bend = (m_ph == lim - 1) && m_cclk;
      crcc = !tb_done && !tb_init_n;
      was_run = (m_st == 4 || m_st == 5);
      ns = m_st;
      m_pulse = 0;
      case (m_st)
        0: if (start) begin ns = 1; m_ok = 0; m_tmo = 0; m_crc = 0; m_left = int'(byte_total); end
        1: if (!tb_init_n) ns = 2; else if (m_tmr == TMO - 1) begin ns = 0; m_tmo = 1; m_pulse = 1; end
        2: if (tb_init_n) ns = 3; else if (m_tmr == TMO - 1) begin ns = 0; m_tmo = 1; m_pulse = 1; end
        3: if (crcc) begin ns = 0; m_crc = 1; m_pulse = 1; end
           else if (m_left == 0) ns = 5;
           else if (s_valid) begin ns = 4; m_byte = s_data; m_bit = 0; m_left--; end
        4: if (bend) begin m_byte = m_byte << 1; m_bit++; if (m_bit == 8) ns = 3; end
        5: if (tb_done) begin ns = 0; m_ok = 1; m_pulse = 1; end
           else if (m_tmr == TMO - 1) begin ns = 0; m_tmo = 1; m_pulse = 1; end
        default: ns = 0;
      endcase
      if (was_run && (ns == 4 || ns == 5)) begin
        if (m_ph == lim - 1) begin m_ph = 0; m_cclk = !m_cclk; end
        else m_ph++;
      end else begin
        m_ph = 0; m_cclk = 0;
      end
      m_tmr = (ns != m_st) ? 0 : m_tmr + 1;
      m_st = ns;
    end
  end

  task automatic cmp(input string tag, input string name, input logic act, input logic exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %b expected %b", tag, name, $time, act, exp);
    end
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  logic hs_q = 1'b0;
  always @(posedge clk) hs_q <= s_valid && s_ready;

  int t_cnt = 0, t_rel = 0, rx_bits = 0, gap_cnt = 0;
  bit t_inrst = 0, prev_cclk = 0;
  logic [7:0] rx_sh = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_rdy, e_din;
      vectors++;
      e_rdy = (m_st == 3) && !(!tb_done && !tb_init_n) && (m_left > 0);
      e_din = (m_st == 5) ? 1'b1 : ((m_st == 4) ? m_byte[7] : 1'b0);
      cmp("R2", "tgt_prog_n", tgt_prog_n, m_st != 1);
      cmp("R5", "tgt_cclk", tgt_cclk, m_cclk);
      cmp("R4", "tgt_din", tgt_din, e_din);
      cmp("R6", "s_ready", s_ready, e_rdy);
      cmp("R1", "busy", busy, m_st != 0);
      cmp("R9", "done_pulse", done_pulse, m_pulse);
      cmp("R8", "load_ok", load_ok, m_ok);
      cmp("R3", "load_timeout", load_timeout, m_tmo);
      cmp("R7", "load_crc_err", load_crc_err, m_crc);
    end
    // emulated target
    if (arm_req != arm_seen) begin
      arm_seen = arm_req; tb_init_n = 1; tb_done = 0; t_inrst = 0;
      t_cnt = 0; t_rel = 0; rx_bits = 0; rx_q.delete(); prev_cclk = 0;
    end else begin
      if (!tgt_prog_n) begin
        rx_bits = 0; tb_done = 0; t_rel = 0; t_cnt++;
        if (!k_never_low && t_cnt >= k_lo_dly) begin tb_init_n = 0; t_inrst = 1; end
      end else begin
        t_cnt = 0;
        if (t_inrst) begin
          t_rel++;
          if (!k_never_high && t_rel >= k_hi_dly) begin tb_init_n = 1; t_inrst = 0; end
        end
      end
      if (tgt_cclk && !prev_cclk) begin
        rx_sh = {rx_sh[6:0], tgt_din};
        rx_bits++;
        if (rx_bits % 8 == 0 && rx_bits <= k_total * 8) rx_q.push_back(rx_sh);
        if (!k_never_done && rx_bits >= k_total * 8 + k_extra) tb_done = 1;
        if (k_crc_byte >= 0 && rx_bits == k_crc_byte * 8 && !tb_done) tb_init_n = 0;
      end
      prev_cclk = tgt_cclk;
    end
    // stream source
    if (hs_q) begin void'(src_q.pop_front()); gap_cnt = k_gap; end
    if (src_q.size() > 0 && gap_cnt == 0) begin s_valid = 1; s_data = src_q[0]; end
    else begin s_valid = 0; if (gap_cnt > 0) gap_cnt--; end
  end

  task automatic run(input logic [7:0] bytes[$], input int div, input int gap, input int extra,
                     input bit nlow, input bit nhigh, input bit ndone, input int crcb,
                     input int poke_start);
    @(negedge clk);
    k_total = bytes.size(); k_gap = gap; k_extra = extra; k_never_low = nlow;
    k_never_high = nhigh; k_never_done = ndone; k_crc_byte = crcb;
    byte_total = 16'(bytes.size()); div_cycles = 8'(div);
    src_q = bytes;
    arm_req++;
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R1", "busy after start", busy, 1);
    chk("R1", "status cleared", {load_ok, load_timeout, load_crc_err}, 0);
    if (poke_start > 0) begin
      repeat (poke_start) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
      chk("R1", "busy kept through ignored start", busy, 1);
    end
    while (!done_pulse) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d[$];
    repeat (4) @(negedge clk);
    chk("R1", "reset busy", busy, 0);
    chk("R2", "reset prog_n", tgt_prog_n, 1);
    chk("R5", "reset cclk", tgt_cclk, 0);
    chk("R6", "reset s_ready", s_ready, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // normal load, divider 1, start poked mid-run (R1, R4, R8)
    d = '{8'hA5, 8'h3C, 8'h01, 8'hFF};
    run(d, 1, 0, 5, 0, 0, 0, -1, 40);
    chk("R8", "ok after load", load_ok, 1);
    chk("R6", "bytes received", rx_q.size(), 4);
    foreach (d[i]) if (i < rx_q.size()) chk("R4", "byte msb-first", rx_q[i], d[i]);
    repeat (3) @(negedge clk);
    chk("R9", "status sticky", load_ok, 1);

    // divider 3 with stream bubbles (R5, R6)
    d = '{8'h80, 8'h6E, 8'h13};
    run(d, 3, 2, 3, 0, 0, 0, -1, 0);
    chk("R8", "ok slow clock", load_ok, 1);
    foreach (d[i]) if (i < rx_q.size()) chk("R4", "slow byte", rx_q[i], d[i]);

    // divider 0 acts as 1 (R5)
    d = '{8'h5A};
    run(d, 0, 0, 2, 0, 0, 0, -1, 0);
    chk("R5", "ok divider zero", load_ok, 1);

    // zero-length run (R10)
    d = {};
    run(d, 2, 0, 4, 0, 0, 0, -1, 0);
    chk("R10", "ok zero bytes", load_ok, 1);

    // init never asserted (R3)
    d = '{8'h11};
    run(d, 1, 0, 2, 1, 0, 0, -1, 0);
    chk("R3", "timeout init low", load_timeout, 1);
    chk("R3", "prog released", tgt_prog_n, 1);

    // init never released (R3), also clears previous status (R9)
    run(d, 1, 0, 2, 0, 1, 0, -1, 0);
    chk("R3", "timeout init high", load_timeout, 1);
    chk("R9", "single flag", load_ok + load_crc_err, 0);

    // done never rises (R3, R8)
    d = '{8'hC3, 8'h00};
    run(d, 2, 0, 2, 0, 0, 1, -1, 0);
    chk("R8", "flush timeout", load_timeout, 1);

    // load error after two bytes (R7)
    d = '{8'h01, 8'h02, 8'h03, 8'h04};
    run(d, 1, 0, 2, 0, 0, 0, 2, 0);
    chk("R7", "crc error", load_crc_err, 1);
    chk("R7", "bytes left unsent", src_q.size(), 2);

    // recovery run after error (R1)
    d = '{8'hE7};
    run(d, 1, 1, 1, 0, 0, 0, -1, 0);
    chk("R1", "ok after error", load_ok, 1);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    fails++;
    $display("FAIL watchdog expired, run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule